// File: doc/BRIEF.md
# Shared Register File with Concurrent-Write Resolution

This block is a small shared register file. A fixed number of processor ports reach it in lockstep. In every cycle each port presents an operation code, an address and write data. The operation is one of three: read, write or idle. All ports see one common address space. Several ports can land on the same entry in the same cycle. The block then applies the access discipline chosen by a 3-bit policy input, which it samples every cycle. Under that policy the collision is either flagged as illegal or merged into a single stored value.

Illegal collisions raise a one-cycle violation flag and report the lowest offending entry. Every write aimed at an offending entry is dropped for that cycle. Writes to all other entries still complete. Reads always return the contents the entry held before the cycle. Read data, the flag and the entry index are all registered and appear one cycle after the request.

Top module: `shared_cw_regfile`

## Requirements
- R1: After reset every entry holds zero, and `rdata_o`, `viol_o` and `viol_addr_o` are zero.
- R2: The per-port operation code is 2'b01 for read, 2'b10 for write, and 2'b00 or 2'b11 for idle. A read presented in cycle t shows, one cycle later, the entry contents from before the writes of cycle t. Ports not reading show zero.
- R3: A legal write updates its entry at the end of its cycle, so a read issued in the following cycle returns the new value.
- R4: Policy 0 (fully exclusive): two or more active ports on one entry in a cycle is a violation, whatever mix of reads and writes they issue.
- R5: Policy 1 (shared read, exclusive write): any number of reads of one entry is legal, but two or more writes to one entry is a violation.
- R6: Policy 2 (zero-only merge): several writes to one entry are legal only when every writer supplies zero. Otherwise they are a violation.
- R7: Policy 3 (unanimous merge): several writes to one entry are legal only when all writers supply identical data. Otherwise they are a violation.
- R8: Policy 4 (any-winner merge): exactly one of the colliding writers' values is stored. The winner is picked starting from a pointer that advances every cycle, so repeated collisions do not always favour one port.
- R9: Policy 5 (rank merge): the value from the highest-numbered writing port is stored.
- R10: Policies 6 and 7 (value merge): bit 0 of the policy is the sub-mode bit. Policy 6 stores the largest colliding value and policy 7 stores the smallest.
- R11: In a cycle with a violation, writes to each offending entry are suppressed and writes to other entries proceed. One cycle later `viol_o` is 1 for exactly one cycle and `viol_addr_o` holds the lowest offending entry. `viol_addr_o` is zero whenever `viol_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 3 | Collision policy, sampled every cycle |
| op_i | input | 2*NPORT | Operation code per port, port p at bits [2p+1:2p] |
| addr_i | input | NPORT*AW | Entry address per port |
| wdata_i | input | NPORT*DW | Write data per port |
| rdata_o | output | NPORT*DW | Registered read data per port |
| viol_o | output | 1 | Registered violation flag |
| viol_addr_o | output | AW | Lowest offending entry of the flagged cycle |

## Verification
Read data and the violation outputs of a request are due one clock edge after the request. A written value can first be observed two edges after the write request, through a read issued in the next cycle. The bench drives each request on a falling edge and samples the outputs on the following falling edge. Its reference model is updated only after that sample, so every compare lines up with the one register stage. For the any-winner policy the stored value is left open. It is checked later, when a read shows a value that must belong to the recorded set of collision values.

// File: rtl/scw_pkg.sv
package scw_pkg;

  typedef enum logic [2:0] {
    POL_EXCL_ALL = 3'd0,
    POL_EXCL_WR  = 3'd1,
    POL_CW_ZERO  = 3'd2,
    POL_CW_SAME  = 3'd3,
    POL_CW_ANY   = 3'd4,
    POL_CW_TOPID = 3'd5,
    POL_CW_MAX   = 3'd6,
    POL_CW_MIN   = 3'd7
  } pol_e;

  localparam logic [1:0] OP_RD = 2'b01;
  localparam logic [1:0] OP_WR = 2'b10;

endpackage

// File: rtl/scw_rr_ptr.sv
module scw_rr_ptr #(
  parameter  int NPORT = 4,
  localparam int PW    = $clog2(NPORT)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr_o
);

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    if (ptr_q == PW'(NPORT - 1)) ptr_d = '0;
    else                         ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/scw_low_idx.sv
module scw_low_idx #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end

endmodule

// File: rtl/scw_addr_lane.sv
module scw_addr_lane
  import scw_pkg::*;
#(
  parameter  int NPORT = 4,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(NPORT)
) (
  input  pol_e                wpol_i,
  input  logic [PW-1:0]       ptr_i,
  input  logic [NPORT-1:0]    wr_mask_i,
  input  logic [NPORT-1:0]    rd_mask_i,
  input  logic [NPORT*DW-1:0] wdata_i,
  output logic                viol_o,
  output logic                we_o,
  output logic [DW-1:0]       wval_o
);

  int            n_wr, n_any, j;
  logic          any_nz, any_diff, found, multi;
  logic [DW-1:0] top_v, max_v, min_v, arb_v;

  // gather per-entry collision statistics
  always_comb begin
    n_wr  = 0;
    n_any = 0;
    top_v = '0;
    max_v = '0;
    min_v = '1;
    for (int i = 0; i < NPORT; i++) begin
      if (wr_mask_i[i]) begin
        n_wr  = n_wr + 1;
        top_v = wdata_i[i*DW +: DW];
        if (wdata_i[i*DW +: DW] > max_v) max_v = wdata_i[i*DW +: DW];
        if (wdata_i[i*DW +: DW] < min_v) min_v = wdata_i[i*DW +: DW];
      end
      if (wr_mask_i[i] || rd_mask_i[i]) n_any = n_any + 1;
    end
    any_nz   = 1'b0;
    any_diff = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (wr_mask_i[i] && (wdata_i[i*DW +: DW] != '0))  any_nz   = 1'b1;
      if (wr_mask_i[i] && (wdata_i[i*DW +: DW] != top_v)) any_diff = 1'b1;
    end
  end

  // rotating pick: first writer at or after the pointer
  always_comb begin
    found = 1'b0;
    arb_v = '0;
    j     = 0;
    for (int k = 0; k < NPORT; k++) begin
      j = int'(ptr_i) + k;
      if (j >= NPORT) j = j - NPORT;
      if (!found && wr_mask_i[j]) begin
        arb_v = wdata_i[j*DW +: DW];
        found = 1'b1;
      end
    end
  end

  // policy decision
  always_comb begin
    multi = (n_wr >= 2);
    unique case (wpol_i)
      POL_EXCL_ALL: viol_o = (n_any >= 2);
      POL_EXCL_WR:  viol_o = multi;
      POL_CW_ZERO:  viol_o = multi && any_nz;
      POL_CW_SAME:  viol_o = multi && any_diff;
      default:      viol_o = 1'b0;
    endcase
    unique case (wpol_i)
      POL_CW_ANY: wval_o = arb_v;
      POL_CW_MAX: wval_o = max_v;
      POL_CW_MIN: wval_o = min_v;
      default:    wval_o = top_v;
    endcase
    we_o = (n_wr != 0) && !viol_o;
  end

endmodule

// File: rtl/shared_cw_regfile.sv
module shared_cw_regfile
  import scw_pkg::*;
#(
  parameter  int NPORT = 4,
  parameter  int AW    = 3,
  parameter  int DW    = 8,
  localparam int DEPTH = 1 << AW,
  localparam int PW    = $clog2(NPORT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          policy_i,
  input  logic [2*NPORT-1:0]  op_i,
  input  logic [NPORT*AW-1:0] addr_i,
  input  logic [NPORT*DW-1:0] wdata_i,
  output logic [NPORT*DW-1:0] rdata_o,
  output logic                viol_o,
  output logic [AW-1:0]       viol_addr_o
);

  pol_e                pol;
  logic [PW-1:0]       rr_ptr;
  logic [NPORT-1:0]    wr_mask [DEPTH];
  logic [NPORT-1:0]    rd_mask [DEPTH];
  logic [DEPTH-1:0]    viol_vec;
  logic [DEPTH-1:0]    lane_we;
  logic [DW-1:0]       lane_wval [DEPTH];
  logic [DW-1:0]       mem_q [DEPTH];
  logic [NPORT*DW-1:0] rdata_d, rdata_q;
  logic                viol_any, viol_q;
  logic [AW-1:0]       viol_idx, vaddr_d, vaddr_q;

  assign pol = pol_e'(policy_i);

  scw_rr_ptr #(.NPORT(NPORT)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ptr_o (rr_ptr)
  );

  // address decode into per-entry port masks
  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      for (int p = 0; p < NPORT; p++) begin
        wr_mask[a][p] = (addr_i[p*AW +: AW] == AW'(a)) && (op_i[2*p +: 2] == OP_WR);
        rd_mask[a][p] = (addr_i[p*AW +: AW] == AW'(a)) && (op_i[2*p +: 2] == OP_RD);
      end
    end
  end

  for (genvar a = 0; a < DEPTH; a++) begin : g_lane
    scw_addr_lane #(.NPORT(NPORT), .DW(DW)) u_lane (
      .wpol_i    (pol),
      .ptr_i     (rr_ptr),
      .wr_mask_i (wr_mask[a]),
      .rd_mask_i (rd_mask[a]),
      .wdata_i   (wdata_i),
      .viol_o    (viol_vec[a]),
      .we_o      (lane_we[a]),
      .wval_o    (lane_wval[a])
    );
  end

  scw_low_idx #(.W(DEPTH), .IW(AW)) u_low (
    .vec_i (viol_vec),
    .any_o (viol_any),
    .idx_o (viol_idx)
  );

  // storage, one enable per entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++) begin
        if (lane_we[a]) mem_q[a] <= lane_wval[a];
      end
    end
  end

  // next-state of output registers
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      if (op_i[2*p +: 2] == OP_RD) rdata_d[p*DW +: DW] = mem_q[addr_i[p*AW +: AW]];
      else                         rdata_d[p*DW +: DW] = '0;
    end
    vaddr_d = viol_any ? viol_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      viol_q  <= 1'b0;
      vaddr_q <= '0;
    end else begin
      rdata_q <= rdata_d;
      viol_q  <= viol_any;
      vaddr_q <= vaddr_d;
    end
  end

  assign rdata_o     = rdata_q;
  assign viol_o      = viol_q;
  assign viol_addr_o = vaddr_q;

endmodule

// File: rtl/scw_checker.sv
module scw_checker #(
  parameter  int NPORT = 4,
  parameter  int AW    = 3,
  parameter  int DW    = 8,
  localparam int DEPTH = 1 << AW,
  localparam int PW    = $clog2(NPORT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          policy_i,
  input logic [2*NPORT-1:0]  op_i,
  input logic [NPORT*AW-1:0] addr_i,
  input logic [NPORT*DW-1:0] rdata_o,
  input logic                viol_o,
  input logic [AW-1:0]       viol_addr_o,
  input logic [DEPTH-1:0]    viol_vec_i,
  input logic [DW-1:0]       mem_i [DEPTH],
  input logic [PW-1:0]       ptr_i
);

  logic [DW-1:0] exp_rd [NPORT];
  logic          coll_any;

  always_comb begin
    for (int p = 0; p < NPORT; p++) exp_rd[p] = mem_i[addr_i[p*AW +: AW]];
    coll_any = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      for (int k = i + 1; k < NPORT; k++) begin
        if ((op_i[2*i +: 2] == 2'b01 || op_i[2*i +: 2] == 2'b10) &&
            (op_i[2*k +: 2] == 2'b01 || op_i[2*k +: 2] == 2'b10) &&
            (addr_i[i*AW +: AW] == addr_i[k*AW +: AW]))
          coll_any = 1'b1;
      end
    end
  end

  a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|viol_vec_i) |=> viol_o);

  a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(|viol_vec_i) |=> !viol_o);

  a_r11_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (viol_addr_o == '0));

  a_r4_excl_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 3'd0 && coll_any) |=> viol_o);

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_i < PW'(NPORT - 1) |=> ptr_i == $past(ptr_i) + 1'b1);

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    a_r11_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
      viol_vec_i[a] |=> (mem_i[a] == $past(mem_i[a])));
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2*p +: 2] != 2'b01) |=> (rdata_o[p*DW +: DW] == '0));
    a_r2_read_old: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[2*p +: 2] == 2'b01) |=> (rdata_o[p*DW +: DW] == $past(exp_rd[p])));
  end

endmodule

bind shared_cw_regfile scw_checker #(.NPORT(NPORT), .AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .policy_i    (policy_i),
  .op_i        (op_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .viol_o      (viol_o),
  .viol_addr_o (viol_addr_o),
  .viol_vec_i  (viol_vec),
  .mem_i       (mem_q),
  .ptr_i       (rr_ptr)
);

// File: tb/shared_cw_regfile_tb_top.sv
`timescale 1ns/1ps
module shared_cw_regfile_tb_top;

  localparam int NP = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NE = 1 << AW;

  logic             clk;
  logic             rst_n;
  logic [2:0]       policy_i;
  logic [2*NP-1:0]  op_i;
  logic [NP*AW-1:0] addr_i;
  logic [NP*DW-1:0] wdata_i;
  logic [NP*DW-1:0] rdata_o;
  logic             viol_o;
  logic [AW-1:0]    viol_addr_o;

  shared_cw_regfile #(.NPORT(NP), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .op_i(op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .viol_o(viol_o), .viol_addr_o(viol_addr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [1:0]    t_op [NP];
  logic [AW-1:0] t_ad [NP];
  logic [DW-1:0] t_wd [NP];
  logic [DW-1:0] model [NE];
  logic [DW-1:0] cand_wd [NE][NP];
  logic [NP-1:0] cand_m [NE];
  logic [DW-1:0] last_arb;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string pol_tag(input logic [2:0] pol);
    case (pol)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic clear_req();
    for (int p = 0; p < NP; p++) begin
      t_op[p] = 2'b00; t_ad[p] = '0; t_wd[p] = '0;
    end
  endtask

  // one request cycle: drive at a falling edge, check at the next one
  task automatic step(input logic [2:0] pol, input string rtag);
    logic [DW-1:0] nm [NE];
    logic          ev;
    logic [AW-1:0] eva;
    policy_i = pol;
    for (int p = 0; p < NP; p++) begin
      op_i[2*p +: 2]    = t_op[p];
      addr_i[p*AW +: AW] = t_ad[p];
      wdata_i[p*DW +: DW] = t_wd[p];
    end
    for (int a = 0; a < NE; a++) nm[a] = model[a];
    ev = 0; eva = '0;
    for (int a = 0; a < NE; a++) begin
      int nw, na, hi;
      bit nz, same, v;
      logic [DW-1:0] fv, mx, mn;
      nw = 0; na = 0; hi = -1; nz = 0; same = 1; fv = '0; mx = '0; mn = '1;
      for (int p = 0; p < NP; p++) begin
        if (t_ad[p] == AW'(a) && t_op[p] == 2'b10) begin
          if (nw == 0) fv = t_wd[p];
          else if (t_wd[p] != fv) same = 0;
          nw++; na++; hi = p;
          if (t_wd[p] != 0) nz = 1;
          if (t_wd[p] > mx) mx = t_wd[p];
          if (t_wd[p] < mn) mn = t_wd[p];
        end else if (t_ad[p] == AW'(a) && t_op[p] == 2'b01) na++;
      end
      case (pol)
        3'd0: v = (na >= 2);
        3'd1: v = (nw >= 2);
        3'd2: v = (nw >= 2) && nz;
        3'd3: v = (nw >= 2) && !same;
        default: v = 0;
      endcase
      if (v && !ev) begin ev = 1; eva = AW'(a); end
      if (!v && nw > 0) begin
        case (pol)
          3'd4: begin
            if (nw == 1) nm[a] = t_wd[hi];
            else begin
              cand_m[a] = '0;
              for (int p = 0; p < NP; p++)
                if (t_ad[p] == AW'(a) && t_op[p] == 2'b10) begin
                  cand_m[a][p] = 1'b1; cand_wd[a][p] = t_wd[p];
                end
            end
          end
          3'd6: nm[a] = mx;
          3'd7: nm[a] = mn;
          default: nm[a] = t_wd[hi];
        endcase
      end
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      logic [DW-1:0] act;
      act = rdata_o[p*DW +: DW];
      if (t_op[p] == 2'b01 && cand_m[t_ad[p]] != 0) begin
        bit hit = 0;
        for (int q = 0; q < NP; q++)
          if (cand_m[t_ad[p]][q] && cand_wd[t_ad[p]][q] == act) hit = 1;
        chk(hit, "R8 stored value is one of the writers", act, cand_wd[t_ad[p]][0]);
        last_arb = act;
        nm[t_ad[p]] = act;
        cand_m[t_ad[p]] = '0;
      end else begin
        chk(act == ((t_op[p] == 2'b01) ? model[t_ad[p]] : '0), rtag, act,
            (t_op[p] == 2'b01) ? model[t_ad[p]] : '0);
      end
    end
    chk(viol_o == ev, ev ? pol_tag(pol) : "R11 flag clear", viol_o, ev);
    chk(viol_addr_o == eva, "R11 lowest entry", viol_addr_o, eva);
    for (int a = 0; a < NE; a++) model[a] = nm[a];
  endtask

  initial begin
    rst_n = 1'b0;
    policy_i = '0; op_i = '0; addr_i = '0; wdata_i = '0;
    last_arb = '0;
    for (int a = 0; a < NE; a++) begin model[a] = '0; cand_m[a] = '0; end
    void'($urandom(32'd1357));
    clear_req();
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    chk(rdata_o == '0, "R1 rdata", rdata_o, 0);
    chk(viol_o == 1'b0, "R1 viol", viol_o, 0);
    chk(viol_addr_o == '0, "R1 viol_addr", viol_addr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every entry reads zero
    for (int b = 0; b < 2; b++) begin
      clear_req();
      for (int p = 0; p < NP; p++) begin t_op[p] = 2'b01; t_ad[p] = AW'(b*4 + p); end
      step(3'd1, "R1 entry zero");
    end
    // R3: single write seen by next-cycle read; R2: same-cycle read sees old value
    clear_req();
    t_op[2] = 2'b10; t_ad[2] = 3'd5; t_wd[2] = 8'h3C;
    t_op[0] = 2'b01; t_ad[0] = 3'd5;
    step(3'd1, "R2 old value");
    clear_req(); t_op[0] = 2'b01; t_ad[0] = 3'd5; t_op[3] = 2'b11;
    step(3'd1, "R3 write visible");
    // R5: concurrent reads legal under policy 1
    clear_req();
    for (int p = 0; p < NP; p++) begin t_op[p] = 2'b01; t_ad[p] = 3'd5; end
    step(3'd1, "R5 shared read");
    // R4 / R11: read plus write on entry 2, second collision on entry 4
    clear_req();
    t_op[0] = 2'b01; t_ad[0] = 3'd4;
    t_op[1] = 2'b10; t_ad[1] = 3'd4; t_wd[1] = 8'h77;
    t_op[2] = 2'b01; t_ad[2] = 3'd2;
    t_op[3] = 2'b10; t_ad[3] = 3'd2; t_wd[3] = 8'h11;
    step(3'd0, "R4 reads");
    clear_req();
    t_op[0] = 2'b01; t_ad[0] = 3'd2; t_op[1] = 2'b01; t_ad[1] = 3'd4;
    step(3'd1, "R11 writes suppressed");
    // R11: writes to a clean entry proceed in a violating cycle
    clear_req();
    t_op[0] = 2'b10; t_ad[0] = 3'd6; t_wd[0] = 8'h01;
    t_op[1] = 2'b10; t_ad[1] = 3'd6; t_wd[1] = 8'h02;
    t_op[2] = 2'b10; t_ad[2] = 3'd1; t_wd[2] = 8'hA5;
    step(3'd1, "R11 other entry");
    clear_req(); t_op[0] = 2'b01; t_ad[0] = 3'd1; t_op[1] = 2'b01; t_ad[1] = 3'd6;
    step(3'd1, "R11 other entry written");
    // R6: zero-only merge, legal then illegal
    clear_req();
    for (int p = 0; p < NP; p++) begin t_op[p] = 2'b10; t_ad[p] = 3'd1; t_wd[p] = 8'h00; end
    step(3'd2, "R6");
    clear_req(); t_op[1] = 2'b01; t_ad[1] = 3'd1;
    step(3'd2, "R6 zero stored");
    clear_req();
    t_op[0] = 2'b10; t_ad[0] = 3'd3; t_wd[0] = 8'h00;
    t_op[3] = 2'b10; t_ad[3] = 3'd3; t_wd[3] = 8'h09;
    step(3'd2, "R6");
    // R7: unanimous merge
    clear_req();
    for (int p = 1; p < NP; p++) begin t_op[p] = 2'b10; t_ad[p] = 3'd7; t_wd[p] = 8'hC3; end
    step(3'd3, "R7");
    clear_req(); t_op[2] = 2'b01; t_ad[2] = 3'd7;
    t_op[0] = 2'b10; t_ad[0] = 3'd0; t_wd[0] = 8'h01;
    t_op[1] = 2'b10; t_ad[1] = 3'd0; t_wd[1] = 8'h02;
    step(3'd3, "R7 common stored");
    // R9: rank merge
    clear_req();
    t_op[1] = 2'b10; t_ad[1] = 3'd0; t_wd[1] = 8'hF0;
    t_op[3] = 2'b10; t_ad[3] = 3'd0; t_wd[3] = 8'h0F;
    t_op[2] = 2'b10; t_ad[2] = 3'd0; t_wd[2] = 8'h55;
    step(3'd5, "R9");
    clear_req(); t_op[0] = 2'b01; t_ad[0] = 3'd0;
    step(3'd5, "R9 highest port stored");
    // R10: value merge, max then min
    clear_req();
    t_op[0] = 2'b10; t_ad[0] = 3'd3; t_wd[0] = 8'h20;
    t_op[1] = 2'b10; t_ad[1] = 3'd3; t_wd[1] = 8'h9B;
    t_op[2] = 2'b10; t_ad[2] = 3'd3; t_wd[2] = 8'h44;
    step(3'd6, "R10");
    clear_req(); t_op[0] = 2'b01; t_ad[0] = 3'd3;
    step(3'd6, "R10 largest stored");
    clear_req();
    t_op[0] = 2'b10; t_ad[0] = 3'd3; t_wd[0] = 8'h20;
    t_op[1] = 2'b10; t_ad[1] = 3'd3; t_wd[1] = 8'h9B;
    t_op[3] = 2'b10; t_ad[3] = 3'd3; t_wd[3] = 8'h31;
    step(3'd7, "R10");
    clear_req(); t_op[3] = 2'b01; t_ad[3] = 3'd3;
    step(3'd7, "R10 smallest stored");
    // R8: any-winner merge, winner must vary over repeated collisions
    begin
      logic [NP-1:0] seen;
      seen = '0;
      for (int r = 0; r < 4; r++) begin
        clear_req();
        for (int p = 0; p < NP; p++) begin t_op[p] = 2'b10; t_ad[p] = 3'd6; t_wd[p] = 8'h40 + DW'(p); end
        step(3'd4, "R8");
        clear_req(); t_op[0] = 2'b01; t_ad[0] = 3'd6;
        step(3'd4, "R8 read");
        if (last_arb >= 8'h40 && last_arb < 8'h40 + NP) seen[last_arb - 8'h40] = 1'b1;
      end
      chk($countones(seen) >= 2, "R8 winner rotates", $countones(seen), 2);
    end
    // constrained random mix, any-winner policy excluded
    for (int n = 0; n < 400; n++) begin
      int pk;
      logic [2:0] pol;
      pk = int'($urandom % 7);
      pol = (pk >= 4) ? 3'(pk + 1) : 3'(pk);
      for (int p = 0; p < NP; p++) begin
        int r;
        t_op[p] = 2'($urandom % 4);
        t_ad[p] = ($urandom % 2 == 0) ? AW'($urandom % 3) : AW'($urandom % NE);
        r = int'($urandom % 4);
        t_wd[p] = (r == 0) ? 8'h00 : (r == 1) ? 8'h5A : DW'($urandom);
      end
      step(pol, "R2 random read");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule